// File: doc/BRIEF.md
# Single-Register Load/Store Transfer Unit

This unit handles the datapath side of one load or one store between a general register and a 32-bit little-endian memory port. It builds the offset from an immediate or from a shifted register value, adds or subtracts it from the base, and picks the access address. In pre-indexed mode the address is the moved base. In post-indexed mode it is the base itself. The unit also produces the new base value and a write enable for the register file.

For stores it copies the byte or halfword across all lanes and asserts only the matching byte enables. For loads it takes the addressed lane out of the memory word and zero- or sign-extends it. A misaligned halfword or word access raises an alignment flag and suppresses the memory strobe. Everything is combinational except a load-result valid, which is registered and rises one cycle after the memory response.

Top module: `ldst_xfer_unit`

## Requirements
- R1: The offset is `imm_i` zero-extended to 32 bits when `use_reg_i`=0. When `use_reg_i`=1 it is `reg_off_i` shifted left logically by `shamt_i`. `base_new_o` is base minus offset when `sub_i`=1, otherwise base plus offset, modulo 2^32.
- R2: When `pre_i`=1, `addr_o` equals `base_new_o` (base moved by the offset).
- R3: When `pre_i`=1, `base_we_o` equals `req_i & wb_i`.
- R4: When `pre_i`=0, `addr_o` equals `base_i`, and `base_we_o` equals `req_i` regardless of `wb_i`.
- R5: Size codes are 0 word, 1 unsigned byte, 2 signed byte, 3 unsigned halfword, 4 signed halfword, and 5 to 7 behave as word. When the strobe is active, `be_o` is `4'b0001 << addr[1:0]` for bytes, `4'b0011 << (2*addr[1])` for halfwords and `4'b1111` for words. `wdata_o` is the low byte of `st_data_i` repeated four times for bytes, the low halfword repeated twice for halfwords, and `st_data_i` for words.
- R6: `ld_data_o` holds the selected lane of `rd_data_i`. The byte lane is bits [8*a+7:8*a] with a = addr[1:0]. The halfword lane is the upper half when addr[1]=1, otherwise the lower half. Codes 2 and 4 fill the upper bits with the lane's top bit, codes 1 and 3 fill them with zeros, and a word load returns `rd_data_i` unchanged.
- R7: `align_err_o` is 1 when `req_i`=1 and either a halfword access has addr[0]=1 or a word access has addr[1:0]≠0. When it is 1, `strobe_o`, `mem_we_o` and `be_o` are all 0. Otherwise `strobe_o`=`req_i` and `mem_we_o`=`strobe_o & is_store_i`.
- R8: `ld_valid_o` is 0 in reset. After reset it equals the value `rsp_i` had at the previous rising clock edge.
- R9: When `req_i`=0, `strobe_o`, `mem_we_o`, `be_o`, `base_we_o` and `align_err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | 1 | Transfer requested this cycle |
| is_store_i | input | 1 | 1 = store, 0 = load |
| size_i | input | 3 | Transfer size/sign code |
| pre_i | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| wb_i | input | 1 | Base writeback request (pre-indexed only) |
| sub_i | input | 1 | Subtract offset instead of adding |
| use_reg_i | input | 1 | Offset from register instead of immediate |
| base_i | input | 32 | Base register value |
| imm_i | input | IMM_W | Immediate offset |
| reg_off_i | input | 32 | Register offset value |
| shamt_i | input | SH_W | Left shift count for the register offset |
| st_data_i | input | 32 | Store source data |
| rd_data_i | input | 32 | Memory read data |
| rsp_i | input | 1 | Memory response valid |
| addr_o | output | 32 | Access address |
| strobe_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write strobe |
| be_o | output | 4 | Byte enables |
| wdata_o | output | 32 | Lane-replicated write data |
| ld_data_o | output | 32 | Extended load result |
| ld_valid_o | output | 1 | Load result valid, one cycle after `rsp_i` |
| base_new_o | output | 32 | Updated base value |
| base_we_o | output | 1 | Base register write enable |
| align_err_o | output | 1 | Misaligned access flag |

## Verification
The bench covers subtraction that wraps below zero, register offsets shifted by large counts, and post-indexed accesses with `wb_i` cleared. A design that ignores writeback in post-indexed mode, or that puts the moved base on the bus, fails the R4 comparisons. It drives every size code at every lane, so a byte-lane swap (big-endian), a halfword taken from the wrong half, or sign fill applied to unsigned codes shows up as a wrong `be_o` or `ld_data_o`. Misaligned halfword and word addresses check that the strobe is suppressed and not just flagged. A one-cycle `rsp_i` pulse shows whether `ld_valid_o` lags by exactly one edge.

// File: rtl/ldst_xfer_unit.sv
module ldst_xfer_unit #(
  parameter int IMM_W = 12,
  parameter int SH_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             is_store_i,
  input  logic [2:0]       size_i,
  input  logic             pre_i,
  input  logic             wb_i,
  input  logic             sub_i,
  input  logic             use_reg_i,
  input  logic [31:0]      base_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [31:0]      reg_off_i,
  input  logic [SH_W-1:0]  shamt_i,
  input  logic [31:0]      st_data_i,
  input  logic [31:0]      rd_data_i,
  input  logic             rsp_i,
  output logic [31:0]      addr_o,
  output logic             strobe_o,
  output logic             mem_we_o,
  output logic [3:0]       be_o,
  output logic [31:0]      wdata_o,
  output logic [31:0]      ld_data_o,
  output logic             ld_valid_o,
  output logic [31:0]      base_new_o,
  output logic             base_we_o,
  output logic             align_err_o
);
  localparam int PAD_W = 32 - IMM_W;

  logic [31:0] offset;
  logic        sz_byte, sz_half, sz_sext;
  logic [3:0]  lane_mask;
  logic [7:0]  ld_byte;
  logic [15:0] ld_half;

  assign offset     = use_reg_i ? (reg_off_i << shamt_i) : {{PAD_W{1'b0}}, imm_i};
  assign base_new_o = sub_i ? (base_i - offset) : (base_i + offset);
  assign addr_o     = pre_i ? base_new_o : base_i;
  assign base_we_o  = req_i & (~pre_i | wb_i);

  assign sz_byte = (size_i == 3'd1) || (size_i == 3'd2);
  assign sz_half = (size_i == 3'd3) || (size_i == 3'd4);
  assign sz_sext = (size_i == 3'd2) || (size_i == 3'd4);

  assign align_err_o = req_i & (sz_half ? addr_o[0] : (~sz_byte & (|addr_o[1:0])));
  assign strobe_o    = req_i & ~align_err_o;
  assign mem_we_o    = strobe_o & is_store_i;

  always_comb begin
    if (sz_byte)      lane_mask = 4'b0001 << addr_o[1:0];
    else if (sz_half) lane_mask = addr_o[1] ? 4'b1100 : 4'b0011;
    else              lane_mask = 4'b1111;
  end
  assign be_o = strobe_o ? lane_mask : 4'b0000;

  assign wdata_o = sz_byte ? {4{st_data_i[7:0]}} :
                   sz_half ? {2{st_data_i[15:0]}} : st_data_i;

  always_comb begin
    case (addr_o[1:0])
      2'd0:    ld_byte = rd_data_i[7:0];
      2'd1:    ld_byte = rd_data_i[15:8];
      2'd2:    ld_byte = rd_data_i[23:16];
      default: ld_byte = rd_data_i[31:24];
    endcase
  end
  assign ld_half = addr_o[1] ? rd_data_i[31:16] : rd_data_i[15:0];

  always_comb begin
    if (sz_byte)      ld_data_o = {{24{sz_sext & ld_byte[7]}}, ld_byte};
    else if (sz_half) ld_data_o = {{16{sz_sext & ld_half[15]}}, ld_half};
    else              ld_data_o = rd_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ld_valid_o <= 1'b0;
    else        ld_valid_o <= rsp_i;
  end

  p_err_blocks_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    align_err_o |-> (!strobe_o && !mem_we_o && be_o == 4'b0000));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |-> (!strobe_o && be_o == 4'b0000 && !base_we_o && !align_err_o));
  p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_i |=> ld_valid_o);
  p_post_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !pre_i) |-> (addr_o == base_i && base_we_o));
  p_byte_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o && sz_byte) |-> $countones(be_o) == 1);
  p_word_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o && !sz_byte && !sz_half) |-> be_o == 4'b1111);
endmodule

// File: tb/sim_ldst_xfer_unit.sv
`timescale 1ns/100ps
module sim_ldst_xfer_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 0, is_store_i = 0, pre_i = 0, wb_i = 0, sub_i = 0, use_reg_i = 0, rsp_i = 0;
  logic [2:0]  size_i = 0;
  logic [31:0] base_i = 0, reg_off_i = 0, st_data_i = 0, rd_data_i = 0;
  logic [11:0] imm_i = 0;
  logic [4:0]  shamt_i = 0;
  logic [31:0] addr_o, wdata_o, ld_data_o, base_new_o;
  logic        strobe_o, mem_we_o, ld_valid_o, base_we_o, align_err_o;
  logic [3:0]  be_o;

  int checks = 0;
  int errors = 0;
  logic rsp_prev = 1'b0;

  always #2.5 clk = ~clk;

  ldst_xfer_unit #(.IMM_W(12), .SH_W(5)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .is_store_i(is_store_i), .size_i(size_i),
    .pre_i(pre_i), .wb_i(wb_i), .sub_i(sub_i), .use_reg_i(use_reg_i), .base_i(base_i),
    .imm_i(imm_i), .reg_off_i(reg_off_i), .shamt_i(shamt_i), .st_data_i(st_data_i),
    .rd_data_i(rd_data_i), .rsp_i(rsp_i), .addr_o(addr_o), .strobe_o(strobe_o),
    .mem_we_o(mem_we_o), .be_o(be_o), .wdata_o(wdata_o), .ld_data_o(ld_data_o),
    .ld_valid_o(ld_valid_o), .base_new_o(base_new_o), .base_we_o(base_we_o),
    .align_err_o(align_err_o));

  always @(posedge clk) rsp_prev <= rst_n ? rsp_i : 1'b0;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    longint unsigned off, nb;
    logic [31:0] e_addr, e_wd, e_ld, e_nb;
    logic [3:0]  e_be;
    logic        e_err, e_stb, e_we;
    int          kind;
    int          lane;
    logic [31:0] pick;
    if (use_reg_i) off = (longint'(reg_off_i) << shamt_i) & 64'hFFFF_FFFF;
    else           off = longint'(imm_i);
    if (sub_i) nb = (longint'(base_i) + 64'h1_0000_0000 - off) & 64'hFFFF_FFFF;
    else       nb = (longint'(base_i) + off) & 64'hFFFF_FFFF;
    e_nb   = nb[31:0];
    e_addr = pre_i ? e_nb : base_i;
    kind = (size_i == 1 || size_i == 2) ? 1 : (size_i == 3 || size_i == 4) ? 2 : 4;
    lane = int'(e_addr[1:0]);
    e_err = req_i && ((kind == 2 && e_addr[0]) || (kind == 4 && lane != 0));
    e_stb = req_i && !e_err;
    e_we  = e_stb && is_store_i;
    if (!e_stb)         e_be = 4'h0;
    else if (kind == 1) e_be = 4'(1 << lane);
    else if (kind == 2) e_be = e_addr[1] ? 4'hC : 4'h3;
    else                e_be = 4'hF;
    if (kind == 1)      e_wd = st_data_i[7:0] * 32'h0101_0101;
    else if (kind == 2) e_wd = st_data_i[15:0] * 32'h0001_0001;
    else                e_wd = st_data_i;
    if (kind == 1) begin
      pick = (rd_data_i >> (8 * lane)) & 32'hFF;
      e_ld = (size_i == 2 && pick[7]) ? (pick | 32'hFFFF_FF00) : pick;
    end else if (kind == 2) begin
      pick = (rd_data_i >> (e_addr[1] ? 16 : 0)) & 32'hFFFF;
      e_ld = (size_i == 4 && pick[15]) ? (pick | 32'hFFFF_0000) : pick;
    end else e_ld = rd_data_i;

    check("R1", "base_new", base_new_o, e_nb);
    check(pre_i ? "R2" : "R4", "addr", addr_o, e_addr);
    check(pre_i ? "R3" : "R4", "base_we", {31'b0, base_we_o}, {31'b0, req_i && (!pre_i || wb_i)});
    check(req_i ? "R5" : "R9", "be", {28'b0, be_o}, {28'b0, e_be});
    check("R5", "wdata", wdata_o, e_wd);
    check("R6", "ld_data", ld_data_o, e_ld);
    check(req_i ? "R7" : "R9", "align_err", {31'b0, align_err_o}, {31'b0, e_err});
    check(req_i ? "R7" : "R9", "strobe", {31'b0, strobe_o}, {31'b0, e_stb});
    check(req_i ? "R7" : "R9", "mem_we", {31'b0, mem_we_o}, {31'b0, e_we});
    check("R8", "ld_valid", {31'b0, ld_valid_o}, {31'b0, rsp_prev});
  endtask

  task automatic cyc();
    @(posedge clk); #1; compare();
    @(negedge clk);
  endtask

  task automatic set(input logic rq, input logic st, input logic [2:0] sz, input logic pr,
                     input logic wb, input logic sb, input logic ur, input logic [31:0] b,
                     input logic [11:0] im, input logic [31:0] ro, input logic [4:0] sh);
    req_i = rq; is_store_i = st; size_i = sz; pre_i = pr; wb_i = wb; sub_i = sb;
    use_reg_i = ur; base_i = b; imm_i = im; reg_off_i = ro; shamt_i = sh;
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1; compare();  // reset state: R8 ld_valid low, R9 idle outputs
    rst_n = 1'b1;
    @(negedge clk);
    st_data_i = 32'hA1B2_C3D4; rd_data_i = 32'h80F1_7F82;
    set(0, 0, 0, 0, 0, 0, 0, 32'h100, 12'h10, 0, 0); cyc();            // R9 idle
    set(1, 0, 0, 1, 0, 0, 0, 32'h100, 12'h10, 0, 0); cyc();            // R2 pre no wb
    set(1, 1, 0, 1, 1, 0, 0, 32'h100, 12'h10, 0, 0); cyc();            // R3 pre wb
    set(1, 0, 0, 0, 0, 0, 0, 32'h200, 12'h8, 0, 0); cyc();             // R4 post, wb clear
    set(1, 0, 0, 1, 1, 1, 0, 32'h4, 12'h8, 0, 0); cyc();               // R1 subtract wraps
    set(1, 0, 0, 1, 0, 0, 1, 32'h1000, 0, 32'h3, 5'd4); cyc();         // R1 shifted reg
    set(1, 0, 0, 0, 1, 1, 1, 32'h1000, 0, 32'hFFFF_FFFF, 5'd31); cyc(); // R1 big shift
    for (int sz = 0; sz < 8; sz++)
      for (int ln = 0; ln < 4; ln++)
        for (int st = 0; st < 2; st++) begin
          set(1, st[0], sz[2:0], 0, 0, 0, 0, 32'h3000 + ln, 0, 0, 0); cyc(); // R5 R6 R7 lanes
        end
    rsp_i = 1; cyc(); rsp_i = 0; cyc(); cyc();                          // R8 pulse
    for (int i = 0; i < 600; i++) begin
      set($urandom_range(0, 3) != 0, $urandom_range(0, 1), 3'($urandom_range(0, 7)),
          $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
          $urandom_range(0, 1), $urandom(), 12'($urandom()), $urandom(), 5'($urandom()));
      st_data_i = $urandom(); rd_data_i = $urandom(); rsp_i = $urandom_range(0, 1);
      cyc();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule